// File: doc/BRIEF.md
# Payload Byte-Strobe Generator

This block turns the byte-enable information of a parsed write-request header into a per-word byte strobe for the payload that follows. A header is presented for one cycle on a load strobe. It carries a 4-bit mask for the opening payload word, a 4-bit mask for the closing payload word, and a 10-bit word count. The block then sits beside the payload stream and watches its valid/ready handshake. For each word it presents the strobe a downstream memory needs to carry out an unaligned partial write.

The opening word takes the opening mask and the closing word takes the closing mask. Every word in between is written in full. A payload of a single word uses only the opening mask. When a header is loaded, the block also checks whether its closing mask is legal for the word count, and raises an error flag. That flag holds until the next header arrives. A new header always restarts the word sequence, even in the middle of a payload.

Top module: `byte_strobe_gen`

## Requirements
- R1: After a header load, the strobe for payload word 0 equals the opening mask. Strobe bit i set means byte lane i of the word is written, so 1100 writes only lanes 3 and 2.
- R2: When the word count is greater than one, the strobe for the final word equals the closing mask, and `beat_last` is 1 only while that word is presented.
- R3: Every word strictly between the first and the final word gets strobe 1111.
- R4: With a word count of one, the single word takes the opening mask, `beat_last` is 1 for it, and the closing mask has no effect on any strobe.
- R5: A length field of 0 means 1024 words: the final word is word index 1023.
- R6: A header with a count greater than one and closing mask 0000 sets `hdr_err` to 1 in the cycle after the load.
- R7: A header with a count of one and a nonzero closing mask sets `hdr_err` to 1. Any other header clears it. The flag holds its value until the next load.
- R8: The word position advances only on a cycle where both `beat_valid` and `beat_ready` are 1. Otherwise the strobe and `beat_last` keep their values.
- R9: A header load restarts the sequence at word 0, even in the middle of a payload and even if a handshake happens in the same cycle.
- R10: After reset, and after the final word of a payload has been accepted, `beat_strb` is 0000 and `beat_last` is 0 until the next load. After reset `hdr_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_load | input | 1 | Capture a new header this cycle |
| hdr_first_be | input | 4 | Byte mask for the opening payload word |
| hdr_last_be | input | 4 | Byte mask for the closing payload word |
| hdr_len | input | 10 | Payload word count, 0 meaning 1024 |
| beat_valid | input | 1 | Payload stream valid |
| beat_ready | input | 1 | Payload stream ready |
| beat_strb | output | 4 | Byte strobe for the word currently offered |
| beat_last | output | 1 | Current word is the final one of the payload |
| hdr_err | output | 1 | Closing mask illegal for the loaded count |

## Verification
The bench builds the block with its default 10-bit length field, so the counter is 11 bits wide. This makes the encoded-zero case reachable: a full 1024-word payload runs through, and its wrap from the largest field value to the largest count is observed on `beat_last`. With the 4-lane mask width, the opening and closing masks can be swept through random and directed values, including 0000 and 1111. That sweep covers both illegal mask and length pairings and the single-word rule. Random stalls on either side of the handshake, together with a reload in the middle of a payload, exercise the counter's hold and restart paths.

// File: rtl/strb_pkg.sv
package strb_pkg;
   typedef enum logic [1:0] {
      POS_IDLE  = 2'd0,
      POS_FIRST = 2'd1,
      POS_MID   = 2'd2,
      POS_LAST  = 2'd3
   } word_pos_t;
endpackage

// File: rtl/strb_hdr_reg.sv
module strb_hdr_reg #(
   parameter int LEN_W  = 10,
   parameter int LANES  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LANES-1:0] first_be,
   input  logic [LANES-1:0] last_be,
   input  logic [LEN_W-1:0] len,
   output logic [LANES-1:0] first_q,
   output logic [LANES-1:0] last_q,
   output logic             err_q
);
   localparam logic [LEN_W-1:0] ONE_WORD = LEN_W'(1);

   logic single_word;
   logic err_d;

   assign single_word = (len == ONE_WORD);
   assign err_d       = single_word ? (last_be != '0) : (last_be == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= '0;
         last_q  <= '0;
         err_q   <= 1'b0;
      end else if (load) begin
         first_q <= first_be;
         last_q  <= last_be;
         err_q   <= err_d;
      end
   end

   AST_ERR_MULTI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (load && len != ONE_WORD && last_be == '0) |=> err_q); // R6
   AST_ERR_SINGLE_NZ: assert property (@(posedge clk) disable iff (!rst_n)
      (load && len == ONE_WORD && last_be != '0) |=> err_q); // R7
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(err_q)); // R7
endmodule

// File: rtl/strb_word_ctr.sv
module strb_word_ctr
   import strb_pkg::*;
#(
   parameter int LEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   input  logic             beat_fire,
   output word_pos_t        pos,
   output logic             word_last
);
   localparam int CW        = LEN_W + 1;
   localparam int MAX_WORDS = 1 << LEN_W;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] total_q;
   logic [CW-1:0] len_words;
   logic          done;
   logic          at_end;
   logic          advance;

   assign len_words = (len == '0) ? CW'(MAX_WORDS) : {1'b0, len};
   assign done      = (cnt_q >= total_q);
   assign at_end    = (cnt_q == total_q - CW'(1));
   assign advance   = beat_fire && !done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         total_q <= '0;
      end else if (load) begin
         cnt_q   <= '0;
         total_q <= len_words;
      end else if (advance) begin
         cnt_q   <= cnt_q + CW'(1);
      end
   end

   always_comb begin
      if (done)                pos = POS_IDLE;
      else if (cnt_q == '0)    pos = POS_FIRST;
      else if (at_end)         pos = POS_LAST;
      else                     pos = POS_MID;
   end

   assign word_last = !done && at_end;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= total_q); // R10
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !beat_fire) |=> $stable(cnt_q)); // R8
   AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/strb_mask_sel.sv
module strb_mask_sel
   import strb_pkg::*;
#(
   parameter int LANES = 4
) (
   input  word_pos_t        pos,
   input  logic [LANES-1:0] first_q,
   input  logic [LANES-1:0] last_q,
   output logic [LANES-1:0] strb
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_comb begin
         unique case (pos)
            POS_FIRST: strb[g] = first_q[g];
            POS_MID:   strb[g] = 1'b1;
            POS_LAST:  strb[g] = last_q[g];
            default:   strb[g] = 1'b0;
         endcase
      end
   end

   always_comb begin
      if (pos == POS_MID) begin
         AST_MID_FULL: assert (&strb); // R3
      end
   end
endmodule

// File: rtl/byte_strobe_gen.sv
module byte_strobe_gen
   import strb_pkg::*;
#(
   parameter int LEN_W = 10,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hdr_load,
   input  logic [LANES-1:0] hdr_first_be,
   input  logic [LANES-1:0] hdr_last_be,
   input  logic [LEN_W-1:0] hdr_len,
   input  logic             beat_valid,
   input  logic             beat_ready,
   output logic [LANES-1:0] beat_strb,
   output logic             beat_last,
   output logic             hdr_err
);
   if (LEN_W < 2 || LEN_W > 16) begin : g_bad_len
      $error("byte_strobe_gen: LEN_W must lie in 2..16");
   end
   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("byte_strobe_gen: LANES must lie in 1..16");
   end

   word_pos_t        pos;
   logic [LANES-1:0] first_q;
   logic [LANES-1:0] last_q;
   logic             beat_fire;

   assign beat_fire = beat_valid && beat_ready;

   strb_hdr_reg #(.LEN_W(LEN_W), .LANES(LANES)) u_hdr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (hdr_load),
      .first_be (hdr_first_be),
      .last_be  (hdr_last_be),
      .len      (hdr_len),
      .first_q  (first_q),
      .last_q   (last_q),
      .err_q    (hdr_err)
   );

   strb_word_ctr #(.LEN_W(LEN_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (hdr_load),
      .len       (hdr_len),
      .beat_fire (beat_fire),
      .pos       (pos),
      .word_last (beat_last)
   );

   strb_mask_sel #(.LANES(LANES)) u_sel (
      .pos     (pos),
      .first_q (first_q),
      .last_q  (last_q),
      .strb    (beat_strb)
   );

   AST_FIRST_STRB: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_load |=> (beat_strb == $past(hdr_first_be))); // R1
   AST_SINGLE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_load && hdr_len == LEN_W'(1)) |=> beat_last); // R4
   AST_LAST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_last && beat_fire && !hdr_load) |=> (!beat_last && beat_strb == '0)); // R10
endmodule

// File: tb/byte_strobe_gen_tb.sv
`timescale 1ns/1ps
module byte_strobe_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hdr_load = 1'b0;
   logic [3:0] hdr_first_be = '0;
   logic [3:0] hdr_last_be = '0;
   logic [9:0] hdr_len = '0;
   logic       beat_valid = 1'b0;
   logic       beat_ready = 1'b0;
   logic [3:0] beat_strb;
   logic       beat_last;
   logic       hdr_err;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   int         m_cnt = 0;
   int         m_total = 0;
   logic [3:0] m_first = '0;
   logic [3:0] m_last = '0;
   logic       m_err = 1'b0;

   always #4 clk = ~clk;

   byte_strobe_gen u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .hdr_load     (hdr_load),
      .hdr_first_be (hdr_first_be),
      .hdr_last_be  (hdr_last_be),
      .hdr_len      (hdr_len),
      .beat_valid   (beat_valid),
      .beat_ready   (beat_ready),
      .beat_strb    (beat_strb),
      .beat_last    (beat_last),
      .hdr_err      (hdr_err)
   );

   function automatic logic [3:0] exp_strb(int cnt, int total, logic [3:0] f, logic [3:0] l);
      if (cnt >= total)           return 4'b0000;
      else if (cnt == 0)          return f;
      else if (cnt == total - 1)  return l;
      else                        return 4'b1111;
   endfunction

   function automatic logic exp_err(int total, logic [3:0] l);
      if (total == 1) return (l != 4'b0000);
      else            return (l == 4'b0000);
   endfunction

   function automatic string pos_tag(int cnt, int total);
      if (cnt >= total)                     return "R10";
      else if (total == 1)                  return "R4";
      else if (cnt == 0)                    return "R1";
      else if (cnt == total - 1)
         return (total == 1024) ? "R5" : "R2";
      else                                  return "R3";
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h (cnt=%0d total=%0d)", tag, act, exp, m_cnt, m_total);
      end
   endtask

   task automatic check_outputs(string tag);
      logic exp_l;
      exp_l = (m_cnt < m_total) && (m_cnt == m_total - 1);
      check(tag, {3'b0, beat_last, beat_strb}, {3'b0, exp_l, exp_strb(m_cnt, m_total, m_first, m_last)});
   endtask

   // Called at a falling edge; ends at the following falling edge with the header loaded.
   task automatic load_hdr(logic [3:0] f, logic [3:0] l, logic [9:0] len, logic hs);
      hdr_first_be = f;
      hdr_last_be  = l;
      hdr_len      = len;
      hdr_load     = 1'b1;
      beat_valid   = hs;
      beat_ready   = hs;
      @(negedge clk);
      hdr_load   = 1'b0;
      beat_valid = 1'b0;
      beat_ready = 1'b0;
      m_cnt   = 0;
      m_total = (len == 10'd0) ? 1024 : int'(len);
      m_first = f;
      m_last  = l;
      m_err   = exp_err(m_total, l);
      #1;
      check((m_total == 1) ? "R7" : "R6", {7'b0, hdr_err}, {7'b0, m_err});
   endtask

   // One cycle of the stream: drive at a falling edge, check, model the next edge.
   task automatic step(logic v, logic r, string tag_override);
      beat_valid = v;
      beat_ready = r;
      #1;
      check_outputs((tag_override != "") ? tag_override : pos_tag(m_cnt, m_total));
      if (v && r && m_cnt < m_total) m_cnt++;
      @(negedge clk);
   endtask

   task automatic run_payload(int pct);
      int guard = 0;
      while (m_cnt < m_total && guard < 20000) begin
         step(($urandom % 100) < pct, ($urandom % 100) < pct, "");
         guard++;
      end
      step(1'b1, 1'b1, "R10");
      check("R7", {7'b0, hdr_err}, {7'b0, m_err});
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240613));
      repeat (3) @(negedge clk);
      #1;
      check("R10", {3'b0, beat_last, beat_strb}, 8'h00);
      check("R10", {7'b0, hdr_err}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed: unaligned start and end over 5 words
      load_hdr(4'b1100, 4'b0011, 10'd5, 1'b0);
      run_payload(100);

      // Single word, legal closing mask
      load_hdr(4'b0110, 4'b0000, 10'd1, 1'b0);
      run_payload(100);

      // Single word, illegal nonzero closing mask: must not reach a strobe
      load_hdr(4'b0001, 4'b1111, 10'd1, 1'b0);
      run_payload(70);

      // Two words with closing mask zero: illegal
      load_hdr(4'b1111, 4'b0000, 10'd2, 1'b0);
      run_payload(100);

      // Stall holds position: valid without ready, then ready without valid
      load_hdr(4'b1000, 4'b0111, 10'd3, 1'b0);
      step(1'b1, 1'b0, "R8");
      step(1'b0, 1'b1, "R8");
      step(1'b1, 1'b1, "R1");
      step(1'b1, 1'b0, "R8");
      step(1'b0, 1'b0, "R8");
      run_payload(100);

      // Reload mid-payload with a handshake in the load cycle
      load_hdr(4'b1110, 4'b0001, 10'd8, 1'b0);
      step(1'b1, 1'b1, "");
      step(1'b1, 1'b1, "");
      step(1'b1, 1'b1, "");
      load_hdr(4'b0101, 4'b1010, 10'd4, 1'b1);
      step(1'b0, 1'b0, "R9");
      run_payload(80);

      // Length field zero: 1024 words
      load_hdr(4'b0011, 4'b1100, 10'd0, 1'b0);
      run_payload(100);

      // Largest encoded value: 1023 words
      load_hdr(4'b0111, 4'b1110, 10'd1023, 1'b0);
      run_payload(90);

      // Constrained random headers
      for (int i = 0; i < 60; i++) begin
         logic [9:0] len;
         logic [3:0] f;
         logic [3:0] l;
         len = ($urandom % 4 == 0) ? 10'(1 + $urandom % 2) : 10'(1 + $urandom % 40);
         f   = 4'($urandom);
         l   = 4'($urandom);
         load_hdr(f, l, len, 1'b0);
         run_payload(40 + int'($urandom % 60));
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule